// File: doc/BRIEF.md
# Serial Transmitter with Programmable Inter-Byte Gap

This block drives an asynchronous serial line, one bit at a time. Every frame is a low start bit, eight data bits taken least significant bit first, and a high stop period. The line is true-high: a high level carries a data value of 1. One bit lasts `rate + 1` system clocks. A free-running tick counter sets the bit edges, and every change of the line happens on one of its ticks. The line is high whenever no frame is in flight.

Bytes come from one of two sources, chosen by `blk_mode`. With `blk_mode` low, the source is a single-cycle write strobe (`wr_en`, `wr_data`), and the stop period is one or two bits as `two_stop` selects. With `blk_mode` high, the source is a valid/ready stream (`s_valid`, `s_data`, `s_ready`), and the stop period comes from a gap register. The stop period in that case is the register value minus nine bit times. Values below ten count as ten, and the register resets to eleven, which gives two stop bits. The stop length is sampled when a frame starts.

The block holds one byte at a time. `tx_rdy` falls on acceptance. It rises again at the edge that begins the last data bit of the frame carrying that byte, so a next byte can be written while the current frame finishes. Stream rules: a byte is transferred on a cycle where `s_valid` and `s_ready` are both high. `s_ready` equals `tx_rdy` in stream mode and is low in write mode. A source may hold `s_valid` high for any length of time, and its data must stay stable until the transfer.

Top module: `serial_gap_tx`

## Requirements
- R1: After reset `txd` is 1, `tx_rdy` is 1, `overrun` is 0, `s_ready` is 0 in write mode, and the gap register holds 11.
- R2: A frame drives 0 for the start bit, then `data[0]` through `data[7]` in that order, then 1 for the stop period. Each bit lasts exactly `rate + 1` clocks, and the line changes only on a tick of the free-running divider, which fires when its count reaches `rate`.
- R3: In write mode the stop period is 1 bit when `two_stop` is 0 and 2 bits when it is 1.
- R4: In stream mode the stop period is (G − 9) bits, where G is the gap register. G is written through `gap_we`/`gap_wdata`, and values below 10 count as 10.
- R5: An accepted byte drives `tx_rdy` low on the next cycle. From idle, its start bit begins at the first divider tick after acceptance, which is within one bit time.
- R6: `tx_rdy` returns to 1 at the same edge at which the last data bit (`data[7]`) begins.
- R7: If a byte is waiting when the stop period ends, its start bit follows immediately, with no idle bit.
- R8: In write mode, a `wr_en` pulse while `tx_rdy` is 0 is ignored and sets `overrun`, which stays at 1 until reset.
- R9: `s_ready` is `tx_rdy` in stream mode and 0 in write mode. `wr_en` has no effect in stream mode, and `s_valid` has no effect in write mode.
- R10: The mode, `two_stop` and the gap value are sampled when a frame's start bit begins. A gap write during a frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_mode | input | 1 | 1 selects the stream source and gap-based stop period |
| two_stop | input | 1 | Write mode: 1 selects two stop bits |
| rate | input | RATE_W | Bit time minus one, in clocks |
| gap_we | input | 1 | Gap register write strobe |
| gap_wdata | input | GAP_W | New gap register value |
| wr_en | input | 1 | Write-mode byte strobe |
| wr_data | input | DATA_W | Write-mode byte |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | DATA_W | Stream byte |
| s_ready | output | 1 | Stream byte can be taken |
| tx_rdy | output | 1 | Holding slot free |
| overrun | output | 1 | Sticky: a write was refused |
| txd | output | 1 | Serial line output |

## Verification
On every cycle, the assertions check four things. The line moves only on a divider tick. An accepted byte pulls `tx_rdy` low and never lands on an occupied slot. A byte taken from the slot starts with a low bit. `overrun` is sticky and only rises after a refused write. The exact stop lengths for each mode and gap value, the edge where `tx_rdy` returns, back-to-back framing, and the sampling of settings when a frame starts cannot be expressed as short properties. The bench's cycle-by-cycle reference model checks those across write-mode, stream-mode and mid-frame gap-write scenarios.

// File: rtl/sgt_pkg.sv
package sgt_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_DATA, PH_STOP} sgt_phase_e;
  localparam int unsigned SGT_GAP_RESET  = 11;
  localparam int unsigned SGT_GAP_FLOOR  = 10;
  localparam int unsigned SGT_GAP_OFFSET = 9;
endpackage

// File: rtl/sgt_baud_tick.sv
module sgt_baud_tick #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [RATE_W-1:0] cnt_q;

  assign tick = (cnt_q >= rate);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rate != '0) |=> (!tick || rate == '0)); // R2
endmodule

// File: rtl/sgt_stop_cfg.sv
module sgt_stop_cfg #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gap_we,
  input  logic [GAP_W-1:0] gap_wdata,
  input  logic             blk_mode,
  input  logic             two_stop,
  output logic [GAP_W-1:0] stop_len
);
  import sgt_pkg::*;
  localparam logic [GAP_W-1:0] GAP_RST = GAP_W'(SGT_GAP_RESET);
  localparam logic [GAP_W-1:0] GAP_FLR = GAP_W'(SGT_GAP_FLOOR);
  localparam logic [GAP_W-1:0] GAP_OFS = GAP_W'(SGT_GAP_OFFSET);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= GAP_RST;
    else if (gap_we) gap_q <= gap_wdata;
  end

  always_comb begin
    if (blk_mode) begin
      if (gap_q < GAP_FLR) stop_len = GAP_FLR - GAP_OFS;
      else                 stop_len = gap_q - GAP_OFS;
    end else begin
      stop_len = two_stop ? GAP_W'(2) : GAP_W'(1);
    end
  end

  AST_STOP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stop_len != '0); // R4
endmodule

// File: rtl/sgt_frame_engine.sv
module sgt_frame_engine #(
  parameter int DATA_W = 8,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic [GAP_W-1:0]  stop_len,
  output logic              take,
  output logic              last_bit,
  output logic              txd
);
  import sgt_pkg::*;
  localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] IDX_PREV = IDX_W'(DATA_W - 2);

  sgt_phase_e        ph_q;
  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic [GAP_W-1:0]  scnt_q;
  logic [GAP_W-1:0]  slen_q;
  logic              stop_end;

  assign stop_end = (ph_q == PH_STOP) && (scnt_q == slen_q);
  assign take     = tick && hold_full && ((ph_q == PH_IDLE) || stop_end);
  assign last_bit = tick && (ph_q == PH_DATA) && (idx_q == IDX_PREV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      sh_q   <= '0;
      idx_q  <= '0;
      scnt_q <= '0;
      slen_q <= '0;
    end else if (tick) begin
      if (take) begin
        ph_q   <= PH_START;
        sh_q   <= hold_data;
        slen_q <= stop_len;
      end else begin
        case (ph_q)
          PH_START: begin
            ph_q  <= PH_DATA;
            idx_q <= '0;
          end
          PH_DATA: begin
            if (idx_q == IDX_LAST) begin
              ph_q   <= PH_STOP;
              scnt_q <= GAP_W'(1);
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          PH_STOP: begin
            if (stop_end) ph_q <= PH_IDLE;
            else          scnt_q <= scnt_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (ph_q)
      PH_START: txd = 1'b0;
      PH_DATA:  txd = sh_q[idx_q];
      default:  txd = 1'b1;
    endcase
  end

  AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txd)); // R2
  AST_TAKE_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !txd); // R7
endmodule

// File: rtl/serial_gap_tx.sv
module serial_gap_tx #(
  parameter int DATA_W = 8,
  parameter int RATE_W = 16,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_mode,
  input  logic              two_stop,
  input  logic [RATE_W-1:0] rate,
  input  logic              gap_we,
  input  logic [GAP_W-1:0]  gap_wdata,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              tx_rdy,
  output logic              overrun,
  output logic              txd
);
  logic              tick, take, last_bit;
  logic              rdy_q, hold_full_q, ovr_q;
  logic [DATA_W-1:0] hold_q;
  logic [GAP_W-1:0]  stop_len;
  logic              wr_ok, s_ok, accept, wr_refused;

  assign wr_ok      = !blk_mode && wr_en && rdy_q;
  assign s_ok       = blk_mode && s_valid && rdy_q;
  assign accept     = wr_ok || s_ok;
  assign wr_refused = !blk_mode && wr_en && !rdy_q;

  assign s_ready = blk_mode && rdy_q;
  assign tx_rdy  = rdy_q;
  assign overrun = ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q       <= 1'b1;
      hold_full_q <= 1'b0;
      hold_q      <= '0;
      ovr_q       <= 1'b0;
    end else begin
      if (accept)        rdy_q <= 1'b0;
      else if (last_bit) rdy_q <= 1'b1;
      if (accept) begin
        hold_full_q <= 1'b1;
        hold_q      <= blk_mode ? s_data : wr_data;
      end else if (take) begin
        hold_full_q <= 1'b0;
      end
      if (wr_refused) ovr_q <= 1'b1;
    end
  end

  sgt_baud_tick #(.RATE_W(RATE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .rate(rate), .tick(tick)
  );

  sgt_stop_cfg #(.GAP_W(GAP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .gap_we(gap_we), .gap_wdata(gap_wdata),
    .blk_mode(blk_mode), .two_stop(two_stop), .stop_len(stop_len)
  );

  sgt_frame_engine #(.DATA_W(DATA_W), .GAP_W(GAP_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hold_full(hold_full_q),
    .hold_data(hold_q), .stop_len(stop_len), .take(take),
    .last_bit(last_bit), .txd(txd)
  );

  AST_RDY_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !tx_rdy); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !hold_full_q); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R8
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(wr_en && !blk_mode)); // R8
endmodule

// File: tb/serial_gap_tx_test.sv
module serial_gap_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       blk_mode = 1'b0, two_stop = 1'b0;
  logic [15:0] rate = 16'd3;
  logic       gap_we = 1'b0;
  logic [7:0] gap_wdata = 8'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = 8'd0;
  logic       s_ready, tx_rdy, overrun, txd;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_gap_tx uut (
    .clk(clk), .rst_n(rst_n), .blk_mode(blk_mode), .two_stop(two_stop),
    .rate(rate), .gap_we(gap_we), .gap_wdata(gap_wdata), .wr_en(wr_en),
    .wr_data(wr_data), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .tx_rdy(tx_rdy), .overrun(overrun), .txd(txd)
  );

  // behavioural reference: a queue of line levels per frame
  int m_cnt, m_gap, m_pos, m_hold;
  bit m_rdy, m_ovr, m_hold_full, m_line;
  int m_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_gap = 11; m_pos = 0; m_hold = 0;
      m_rdy = 1; m_ovr = 0; m_hold_full = 0; m_line = 1;
      m_q.delete();
    end else begin
      bit tk, acc;
      int nstop;
      tk  = (m_cnt >= int'(rate));
      acc = m_rdy && ((!blk_mode && wr_en) || (blk_mode && s_valid));
      if (!blk_mode && wr_en && !m_rdy) m_ovr = 1;
      if (tk) begin
        if (m_q.size() == 0 && m_hold_full) begin
          if (blk_mode) nstop = (m_gap < 10) ? 1 : m_gap - 9;
          else          nstop = two_stop ? 2 : 1;
          m_q.push_back(0);
          for (int i = 0; i < 8; i++) m_q.push_back((m_hold >> i) & 1);
          for (int i = 0; i < nstop; i++) m_q.push_back(1);
          m_hold_full = 0;
          m_pos = 0;
        end
        if (m_q.size() > 0) begin
          m_line = m_q.pop_front();
          m_pos++;
          if (m_pos == 9) m_rdy = 1;
        end
        m_cnt = 0;
      end else begin
        m_cnt++;
      end
      if (acc) begin
        m_hold = blk_mode ? int'(s_data) : int'(wr_data);
        m_hold_full = 1;
        m_rdy = 0;
      end
      if (gap_we) m_gap = int'(gap_wdata);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(txd == m_line, "R2 txd", txd, m_line);
      chk(tx_rdy == m_rdy, "R6 tx_rdy", tx_rdy, m_rdy);
      chk(s_ready == (m_rdy && blk_mode), "R9 s_ready", s_ready, m_rdy && blk_mode);
      chk(overrun == m_ovr, "R8 overrun", overrun, m_ovr);
    end
  end

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk);
    while (!tx_rdy) @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic stream(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1; s_data = 8'(base + 37 * i);
      #1;
      while (!s_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    s_valid = 1'b0;
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (!(tx_rdy && m_q.size() == 0 && !m_hold_full)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic write_gap(input logic [7:0] g);
    @(negedge clk);
    gap_we = 1'b1; gap_wdata = g;
    @(negedge clk);
    gap_we = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lows;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    chk(tx_rdy == 1'b1, "R1 tx_rdy", tx_rdy, 1);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);
    chk(s_ready == 1'b0, "R1 s_ready", s_ready, 0);

    // R2 R3 R5 single byte, one stop bit
    send_byte(8'hA5);
    chk(tx_rdy == 1'b0, "R5 rdy low after write", tx_rdy, 0);
    wait_idle();
    // R3 two stop bits
    two_stop = 1'b1;
    send_byte(8'h3C);
    wait_idle();
    // R7 back to back
    send_byte(8'h01); send_byte(8'h80); send_byte(8'hF0);
    wait_idle();
    two_stop = 1'b0;
    send_byte(8'h5A); send_byte(8'hC3);
    wait_idle();

    // R8 overrun
    send_byte(8'h77);
    wr_en = 1'b1; wr_data = 8'h11;
    @(negedge clk);
    wr_en = 1'b0;
    chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
    wait_idle();
    chk(overrun == 1'b1, "R8 overrun sticky", overrun, 1);

    // R2 fastest rate
    rate = 16'd0;
    send_byte(8'h96); send_byte(8'h69);
    wait_idle();

    // R9 s_valid ignored in write mode
    rate = 16'd2;
    lows = 0;
    s_valid = 1'b1; s_data = 8'h00;
    repeat (40) begin @(negedge clk); if (!txd) lows++; end
    s_valid = 1'b0;
    chk(lows == 0, "R9 s_valid ignored in write mode", lows, 0);
    chk(tx_rdy == 1'b1, "R9 tx_rdy untouched", tx_rdy, 1);

    // R4 stream mode, default gap 11
    blk_mode = 1'b1;
    stream(3, 8'h21);
    wait_idle();
    // R4 gap below floor
    write_gap(8'd5);
    stream(2, 8'h44);
    wait_idle();
    write_gap(8'd14);
    stream(3, 8'h0F);
    wait_idle();
    // R10 gap write during a frame
    write_gap(8'd10);
    fork
      stream(3, 8'hB2);
      begin repeat (12) @(negedge clk); gap_we = 1'b1; gap_wdata = 8'd13; @(negedge clk); gap_we = 1'b0; end
    join
    wait_idle();

    // R9 wr_en ignored in stream mode
    lows = 0;
    wr_en = 1'b1; wr_data = 8'h00;
    repeat (40) begin @(negedge clk); if (!txd) lows++; end
    wr_en = 1'b0;
    chk(lows == 0, "R9 wr_en ignored in stream mode", lows, 0);
    chk(tx_rdy == 1'b1, "R9 tx_rdy after ignored wr_en", tx_rdy, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule